// File: doc/BRIEF.md
# Drive Security Lock Controller

This block is the control core of a storage device's password security feature. Each cycle it can take one decoded security command: set password, unlock, erase prepare, erase unit, freeze, disable password, or any other command. With the command come a master/user identifier, a requested level for password setting, and a password match result. Password storage and comparison happen outside the block. For each command the block returns one registered verdict, accept or abort, one cycle later. It also keeps the enabled, locked, frozen and level flags and the remaining unlock attempts.

Whether security is enabled and which level it uses come in on boot inputs at reset. If security is enabled there, the device comes up locked. Wrong unlock passwords use up a bounded number of attempts, and once none are left, unlocking and erasing stay blocked until reset. A freeze blocks every command that could change the lock state, and only reset clears it. An erase unit goes through only when the security command just before it was an erase prepare. When it goes through, the block raises a one-cycle erase start pulse that the media logic acts on.

Top module: `sec_lock_ctrl`

## Requirements
- R1: During and after reset, tries_left equals TRY_LIMIT (default 5), sec_frozen is 0, no erase is armed, sec_enabled and sec_locked both equal boot_enabled, and sec_level_max equals boot_level_max.
- R2: cmd_code values are 0 other, 1 set password, 2 unlock, 3 erase prepare, 4 erase unit, 5 freeze, 6 disable password, 7 other. Every cmd_valid cycle gives rsp_valid in the following cycle, with exactly one of rsp_accept and rsp_abort high. Neither is high without rsp_valid.
- R3: An unlock with pw_match high (when not blocked by R4, R5 or R8) is accepted and clears sec_locked. An unlock with pw_match low is aborted. It lowers tries_left by one only while sec_locked is 1.
- R4: Once tries_left is 0, unlock and erase unit are aborted whatever pw_match is, and tries_left stays 0 until reset.
- R5: Freeze is always accepted and sets sec_frozen, including when the block is already frozen. While frozen, set password, unlock, erase prepare, erase unit and disable password are aborted, and sec_enabled, sec_locked and sec_level_max do not change.
- R6: Once set, sec_frozen stays 1 until reset, and reset clears it.
- R7: Erase unit is accepted only if the previous command was erase prepare and pw_match is high. Idle cycles between the two do not break the pairing. On acceptance, erase_start pulses for one cycle together with the response, and sec_enabled, sec_locked and sec_level_max clear.
- R8: An unlock with cmd_id_master high is aborted when sec_level_max is 1, and tries_left does not change. When sec_level_max is 0, it follows R3.
- R9: Set password is aborted when the block is locked or frozen. Otherwise it is accepted. With the user identifier it sets sec_enabled and loads sec_level_max from cmd_level_max. With the master identifier it changes no flag.
- R10: Disable password is accepted when not frozen and pw_match is high, and it clears sec_enabled and sec_locked. It is aborted on a mismatch, and no flag changes.
- R11: Any other command is accepted, changes no flag, and disarms a pending erase prepare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or hardware reset) |
| boot_enabled | input | 1 | Non-volatile enabled flag loaded at reset |
| boot_level_max | input | 1 | Non-volatile level flag loaded at reset (1 = maximum) |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Decoded command, encoding per R2 |
| cmd_id_master | input | 1 | 1 = master identifier, 0 = user |
| cmd_level_max | input | 1 | Requested level for set password |
| pw_match | input | 1 | External password compare result |
| rsp_valid | output | 1 | Verdict present |
| rsp_accept | output | 1 | Command accepted |
| rsp_abort | output | 1 | Command aborted |
| erase_start | output | 1 | One-cycle erase trigger |
| sec_enabled | output | 1 | Security enabled |
| sec_locked | output | 1 | Device locked |
| sec_frozen | output | 1 | Frozen |
| sec_level_max | output | 1 | Level (1 = maximum, 0 = high) |
| tries_left | output | TRY_W | Unlock attempts remaining |

## Verification
The assertions assume that pw_match, cmd_code and the identifier are settled whenever cmd_valid is high. They also assume that the boot inputs hold steady while reset is low. Neither assumption is checked. The stimulus drives every command field together at the falling edge and changes the boot values only while reset is held. The random mix weights the unlock and erase pairings heavily so that attempt exhaustion, frozen phases and prepare/erase sequences, with and without idle gaps, all occur.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;
   typedef enum logic [2:0] {
      SC_OTHER   = 3'd0,
      SC_SET_PW  = 3'd1,
      SC_UNLOCK  = 3'd2,
      SC_PREP    = 3'd3,
      SC_ERASE   = 3'd4,
      SC_FREEZE  = 3'd5,
      SC_DISABLE = 3'd6,
      SC_OTHER_B = 3'd7
   } sec_cmd_e;

   typedef struct packed {
      logic enabled;
      logic locked;
      logic frozen;
      logic lvl_max;
   } sec_state_t;
endpackage

// File: rtl/sec_try_counter.sv
module sec_try_counter #(
   parameter int TRY_LIMIT = 5,
   parameter int TRY_W     = $clog2(TRY_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             burn,
   output logic [TRY_W-1:0] count,
   output logic             zero
);
   localparam logic [TRY_W-1:0] START = TRY_W'(TRY_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= START;
      else if (burn && (count != '0))
         count <= count - 1'b1;
   end

   assign zero = (count == '0);

   // R4: the attempt count never rises outside reset
   p_tries_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count <= $past(count)));

   // R4: exhaustion holds until reset
   p_tries_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> zero);
endmodule

// File: rtl/sec_prep_tracker.sv
module sec_prep_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic is_prep,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (cmd_valid)
         armed <= is_prep;
   end

   // R7: idle cycles keep the pairing
   p_armed_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid) |=> $stable(armed));
endmodule

// File: rtl/sec_verdict.sv
module sec_verdict
   import sec_lock_pkg::*;
#(
   parameter bit ERASE_BURNS_TRY = 1'b0
) (
   input  sec_cmd_e   cmd,
   input  logic       id_master,
   input  logic       lvl_req,
   input  logic       pw_match,
   input  logic       tries_zero,
   input  logic       prep_armed,
   input  sec_state_t cur,
   output sec_state_t nxt,
   output logic       accept,
   output logic       burn,
   output logic       erase_go
);
   logic burn_unlock;
   logic burn_erase;

   always_comb begin
      nxt         = cur;
      accept      = 1'b0;
      burn_unlock = 1'b0;
      burn_erase  = 1'b0;
      erase_go    = 1'b0;
      unique case (cmd)
         SC_SET_PW: begin
            if (!cur.frozen && !cur.locked) begin
               accept = 1'b1;
               if (!id_master) begin
                  nxt.enabled = 1'b1;
                  nxt.lvl_max = lvl_req;
               end
            end
         end
         SC_UNLOCK: begin
            if (!cur.frozen && !tries_zero && !(id_master && cur.lvl_max)) begin
               if (pw_match) begin
                  accept     = 1'b1;
                  nxt.locked = 1'b0;
               end else begin
                  burn_unlock = cur.locked;
               end
            end
         end
         SC_PREP: accept = !cur.frozen;
         SC_ERASE: begin
            if (!cur.frozen && !tries_zero && prep_armed) begin
               if (pw_match) begin
                  accept      = 1'b1;
                  erase_go    = 1'b1;
                  nxt.enabled = 1'b0;
                  nxt.locked  = 1'b0;
                  nxt.lvl_max = 1'b0;
               end else begin
                  burn_erase = cur.locked;
               end
            end
         end
         SC_FREEZE: begin
            accept     = 1'b1;
            nxt.frozen = 1'b1;
         end
         SC_DISABLE: begin
            if (!cur.frozen && pw_match) begin
               accept      = 1'b1;
               nxt.enabled = 1'b0;
               nxt.locked  = 1'b0;
            end
         end
         default: accept = 1'b1;
      endcase
   end

   generate
      if (ERASE_BURNS_TRY) begin : g_erase_burn
         assign burn = burn_unlock | burn_erase;
      end else begin : g_unlock_burn
         logic erase_burn_unused;
         assign erase_burn_unused = burn_erase;
         assign burn = burn_unlock | (erase_burn_unused & 1'b0);
      end
   endgenerate
endmodule

// File: rtl/sec_lock_ctrl.sv
module sec_lock_ctrl
   import sec_lock_pkg::*;
#(
   parameter int TRY_LIMIT       = 5,
   parameter bit ERASE_BURNS_TRY = 1'b0,
   parameter int TRY_W           = $clog2(TRY_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_enabled,
   input  logic             boot_level_max,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_code,
   input  logic             cmd_id_master,
   input  logic             cmd_level_max,
   input  logic             pw_match,
   output logic             rsp_valid,
   output logic             rsp_accept,
   output logic             rsp_abort,
   output logic             erase_start,
   output logic             sec_enabled,
   output logic             sec_locked,
   output logic             sec_frozen,
   output logic             sec_level_max,
   output logic [TRY_W-1:0] tries_left
);
   generate
      if (TRY_LIMIT < 1) begin : g_bad_limit
         $error("TRY_LIMIT must be at least 1");
      end
      if (TRY_W < $clog2(TRY_LIMIT + 1)) begin : g_bad_width
         $error("TRY_W too narrow for TRY_LIMIT");
      end
   endgenerate

   sec_cmd_e   cmd;
   sec_state_t st_q;
   sec_state_t st_d;
   logic       accept;
   logic       burn;
   logic       erase_go;
   logic       tries_zero;
   logic       prep_armed;

   assign cmd = sec_cmd_e'(cmd_code);

   sec_try_counter #(.TRY_LIMIT(TRY_LIMIT), .TRY_W(TRY_W)) u_tries (
      .clk   (clk),
      .rst_n (rst_n),
      .burn  (cmd_valid & burn),
      .count (tries_left),
      .zero  (tries_zero)
   );

   sec_prep_tracker u_prep (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .is_prep   (cmd == SC_PREP),
      .armed     (prep_armed)
   );

   sec_verdict #(.ERASE_BURNS_TRY(ERASE_BURNS_TRY)) u_verdict (
      .cmd        (cmd),
      .id_master  (cmd_id_master),
      .lvl_req    (cmd_level_max),
      .pw_match   (pw_match),
      .tries_zero (tries_zero),
      .prep_armed (prep_armed),
      .cur        (st_q),
      .nxt        (st_d),
      .accept     (accept),
      .burn       (burn),
      .erase_go   (erase_go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q.enabled <= boot_enabled;
         st_q.locked  <= boot_enabled;
         st_q.frozen  <= 1'b0;
         st_q.lvl_max <= boot_level_max;
         rsp_valid    <= 1'b0;
         rsp_accept   <= 1'b0;
         rsp_abort    <= 1'b0;
         erase_start  <= 1'b0;
      end else begin
         if (cmd_valid)
            st_q <= st_d;
         rsp_valid   <= cmd_valid;
         rsp_accept  <= cmd_valid & accept;
         rsp_abort   <= cmd_valid & !accept;
         erase_start <= cmd_valid & erase_go;
      end
   end

   assign sec_enabled   = st_q.enabled;
   assign sec_locked    = st_q.locked;
   assign sec_frozen    = st_q.frozen;
   assign sec_level_max = st_q.lvl_max;

   // R2: exactly one verdict per response
   p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_accept, rsp_abort}));
   p_no_stray_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_accept || rsp_abort));

   // R7: erase only after an armed prepare
   p_erase_after_prep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> ($past(prep_armed) && rsp_accept));

   // R6: freeze is sticky
   p_frozen_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_frozen |=> sec_frozen);

   // R5: no lock change while frozen
   p_frozen_holds_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_frozen |=> ($stable(sec_locked) && $stable(sec_enabled) && $stable(sec_level_max)));

   // R4: exhausted attempts block unlock
   p_zero_blocks_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd == SC_UNLOCK) && (tries_left == '0)) |=> rsp_abort);
endmodule

// File: tb/sec_lock_ctrl_bench.sv
module sec_lock_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boot_enabled = 1'b0, boot_level_max = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic cmd_id_master = 1'b0, cmd_level_max = 1'b0, pw_match = 1'b0;
   logic rsp_valid, rsp_accept, rsp_abort, erase_start;
   logic sec_enabled, sec_locked, sec_frozen, sec_level_max;
   logic [2:0] tries_left;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // model state
   logic m_en, m_lk, m_fz, m_lv, m_pp;
   int   m_tr;

   always #10 clk = ~clk;

   sec_lock_ctrl u_sec_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .boot_enabled(boot_enabled), .boot_level_max(boot_level_max),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_id_master(cmd_id_master),
      .cmd_level_max(cmd_level_max), .pw_match(pw_match),
      .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_abort(rsp_abort),
      .erase_start(erase_start), .sec_enabled(sec_enabled), .sec_locked(sec_locked),
      .sec_frozen(sec_frozen), .sec_level_max(sec_level_max), .tries_left(tries_left)
   );

   task automatic chk(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   function automatic string tag_of(logic [2:0] c);
      case (c)
         3'd1: return "R9";
         3'd2: return "R3";
         3'd3, 3'd4: return "R7";
         3'd5: return "R5";
         3'd6: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check_state(string tag);
      chk(tag, "enabled", sec_enabled, m_en);
      chk(tag, "locked", sec_locked, m_lk);
      chk(tag, "frozen", sec_frozen, m_fz);
      chk(tag, "level", sec_level_max, m_lv);
      chk(tag, "tries", tries_left, m_tr);
   endtask

   task automatic do_reset(logic be, logic bl);
      rst_n = 1'b0;
      boot_enabled = be;
      boot_level_max = bl;
      @(posedge clk);
      @(negedge clk);
      m_en = be; m_lk = be; m_fz = 1'b0; m_lv = bl; m_pp = 1'b0; m_tr = 5;
      check_state("R1");
      chk("R1", "rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;
   endtask

   // Expected verdict from the requirements
   task automatic model(logic [2:0] c, logic idm, logic lvl, logic mt,
                        output logic acc, output logic ers);
      acc = 1'b0; ers = 1'b0;
      case (c)
         3'd1: if (!m_fz && !m_lk) begin
            acc = 1'b1;
            if (!idm) begin m_en = 1'b1; m_lv = lvl; end
         end
         3'd2: if (!m_fz && m_tr != 0 && !(idm && m_lv)) begin
            if (mt) begin acc = 1'b1; m_lk = 1'b0; end
            else if (m_lk) m_tr = m_tr - 1;
         end
         3'd3: acc = !m_fz;
         3'd4: if (!m_fz && m_tr != 0 && m_pp && mt) begin
            acc = 1'b1; ers = 1'b1; m_en = 1'b0; m_lk = 1'b0; m_lv = 1'b0;
         end
         3'd5: begin acc = 1'b1; m_fz = 1'b1; end
         3'd6: if (!m_fz && mt) begin acc = 1'b1; m_en = 1'b0; m_lk = 1'b0; end
         default: acc = 1'b1;
      endcase
      m_pp = (c == 3'd3);
   endtask

   task automatic issue(logic [2:0] c, logic idm, logic lvl, logic mt, string tag);
      logic acc, ers;
      model(c, idm, lvl, mt, acc, ers);
      cmd_valid = 1'b1; cmd_code = c; cmd_id_master = idm;
      cmd_level_max = lvl; pw_match = mt;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R2", "rsp_valid", rsp_valid, 1);
      chk(tag, "accept", rsp_accept, acc);
      chk("R2", "abort", rsp_abort, !acc);
      chk(tag, "erase_start", erase_start, ers);
      check_state(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R2", "idle rsp_valid", rsp_valid, 0);
         chk("R7", "idle erase_start", erase_start, 0);
      end
   endtask

   initial begin
      void'($urandom(32'h5EC0_0A11));
      @(negedge clk);
      do_reset(1'b0, 1'b0);
      issue(3'd0, 0, 0, 0, "R11");
      issue(3'd7, 0, 0, 1, "R11");
      issue(3'd1, 0, 1, 0, "R9");
      issue(3'd1, 1, 0, 0, "R9");
      issue(3'd6, 0, 0, 0, "R10");
      issue(3'd6, 0, 0, 1, "R10");
      // attempt exhaustion
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < 5; i++) issue(3'd2, 0, 0, 0, "R3");
      issue(3'd2, 0, 0, 1, "R4");
      issue(3'd3, 0, 0, 1, "R4");
      issue(3'd4, 0, 0, 1, "R4");
      issue(3'd1, 0, 0, 0, "R9");
      do_reset(1'b1, 1'b0);
      chk("R6", "tries after reset", tries_left, 5);
      // master at maximum level
      do_reset(1'b1, 1'b1);
      issue(3'd2, 1, 0, 1, "R8");
      issue(3'd2, 1, 0, 0, "R8");
      issue(3'd2, 0, 0, 1, "R3");
      do_reset(1'b1, 1'b0);
      issue(3'd2, 1, 0, 1, "R8");
      // prepare/erase ordering
      issue(3'd4, 0, 0, 1, "R7");
      issue(3'd3, 0, 0, 1, "R7");
      issue(3'd0, 0, 0, 1, "R11");
      issue(3'd4, 0, 0, 1, "R7");
      issue(3'd3, 0, 0, 1, "R7");
      idle(3);
      issue(3'd4, 0, 0, 1, "R7");
      // freeze
      issue(3'd1, 0, 1, 0, "R9");
      issue(3'd5, 0, 0, 0, "R5");
      issue(3'd5, 0, 0, 0, "R5");
      issue(3'd6, 0, 0, 1, "R5");
      issue(3'd3, 0, 0, 1, "R5");
      issue(3'd2, 0, 0, 1, "R5");
      do_reset(1'b0, 1'b0);
      chk("R6", "frozen after reset", sec_frozen, 0);
      // random mix
      for (int n = 0; n < 1500; n++) begin
         int r = $urandom_range(0, 99);
         logic [2:0] c;
         if (r < 2) begin
            do_reset(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            continue;
         end
         if (r < 22) c = 3'd2;
         else if (r < 38) c = 3'd3;
         else if (r < 54) c = 3'd4;
         else if (r < 58) c = 3'd5;
         else c = 3'($urandom_range(0, 7));
         issue(c, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 9) < 6), tag_of(c));
         if ($urandom_range(0, 9) == 0) idle(1);
      end
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule